// File: doc/BRIEF.md
# Limited-Range Coefficient Scaler

This block takes a stream of colour-matrix coefficients in 64-bit sign-magnitude form (sign in bit 63, magnitude in bits 62:0 with 32 fractional bits). It multiplies each magnitude by the ratio of the limited video swing to the full swing, (235 − 16) / 255. A full-range matrix fed with the scaled coefficients then produces output that fits the 16..235 code range. The result keeps the input format, so it can go straight into whatever coefficient encoder follows.

The scale factor is held as an unsigned 32-bit fixed-point constant, floor(219 · 2^32 / 255) = 0xDBDBDBDB. Before the 32×32 multiply, the magnitude is clamped just below 4.0 and divided by four. The 64-bit product is then shifted right by 30 to realign it. The sign bypasses the multiplier. Coefficients arrive one per valid/ready transfer in row-major order, nine per matrix, and each result carries its position within the matrix. The block also drives, as a constant, the per-channel post-offset that goes with limited range, in a 12-bit-fraction format.

Top module: `lr_coef_scaler`

## Requirements
- R1: After reset, out_valid is 0, out_idx is 0 and in_ready is 1.
- R2: For an input magnitude M below 2^34, the output magnitude (bits 62:0) equals (0xDBDBDBDB · floor(M / 4)) >> 30. For example, 1.0 (2^32) maps to 0xDBDBDBDB, 0.5 maps to 0x6DEDEDED, 2.0 maps to 0x1B7B7B7B6 and 4 LSBs map to 3 LSBs. Output bits 62:34 are always 0.
- R3: An input magnitude of 2^34 or more gives the same output as 2^34 − 1, which is magnitude 0x36F6F6F68.
- R4: Output bit 63 equals input bit 63 of the same coefficient.
- R5: A zero magnitude (and any magnitude below 4 LSBs) gives a zero magnitude, with the sign bit still copied, so −0 stays −0.
- R6: With out_ready held at 1, a coefficient accepted in cycle n appears on the output with out_valid = 1 in cycle n + 2. Back-to-back inputs give one result per cycle, in order.
- R7: While out_valid = 1 and out_ready = 0, out_coef and out_valid hold steady and in_ready is 0.
- R8: out_idx gives the position 0..8 of the current result within its matrix. It advances on each output transfer and wraps from 8 back to 0.
- R9: out_offset is the constant 16 · 4096 / 255 rounded down, which is 257.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input coefficient is valid |
| in_ready | output | 1 | Block can accept a coefficient |
| in_coef | input | 64 | Sign-magnitude coefficient, 32 fraction bits |
| out_valid | output | 1 | Scaled coefficient is valid |
| out_ready | input | 1 | Consumer accepts the result |
| out_coef | output | 64 | Scaled coefficient, same format as the input |
| out_idx | output | 4 | Position of the result in the matrix, 0..8 |
| out_offset | output | 16 | Limited-range post-offset, 12 fraction bits |

## Verification
When the consumer is ready, every scaled coefficient is due two cycles after the cycle in which it was accepted. The constant offset and the reset values are due at once. Inputs change one time unit after a rising edge and outputs are read on the falling edge. A directed test counts the two idle falling edges before the result and checks that it lands on the third. The vector walk pushes coefficients back to back and matches each result, in order, against a hand-computed table as it leaves the block. This makes the check independent of the exact cycle. The stall test reads the held result several falling edges apart, and checks that it is released one edge after out_ready rises.

// File: rtl/lr_coef_scaler.sv
module lr_coef_scaler #(
  parameter int FULL_HI  = 255,
  parameter int LIM_LO   = 16,
  parameter int LIM_HI   = 235,
  parameter int NUM_COEF = 9,
  parameter int OFS_FRAC = 12,
  parameter int IDX_W    = $clog2(NUM_COEF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [63:0]      in_coef,
  output logic             out_valid,
  input  logic             out_ready,
  output logic [63:0]      out_coef,
  output logic [IDX_W-1:0] out_idx,
  output logic [15:0]      out_offset
);
  localparam logic [63:0] SCALE64 = (64'(LIM_HI - LIM_LO) << 32) / 64'(FULL_HI);
  localparam logic [31:0] SCALE   = SCALE64[31:0];
  localparam logic [15:0] OFS     = 16'((LIM_LO * (1 << OFS_FRAC)) / FULL_HI);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_COEF - 1);

  logic        adv, acc;
  logic        v1, s1, v2, s2;
  logic [31:0] m1;
  logic [63:0] p2;
  logic [33:0] low34;
  logic [31:0] mag_in;
  logic [IDX_W-1:0] idx;

  assign adv    = out_ready | ~v2;
  assign acc    = in_valid & adv;
  assign low34  = in_coef[33:0];
  assign mag_in = (|in_coef[62:34]) ? 32'hFFFF_FFFF : 32'(low34 >> 2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0;
      v2 <= 1'b0;
      s1 <= 1'b0;
      s2 <= 1'b0;
      m1 <= '0;
      p2 <= '0;
    end else if (adv) begin
      v1 <= in_valid;
      s1 <= in_coef[63];
      m1 <= mag_in;
      v2 <= v1;
      s2 <= s1;
      p2 <= {32'd0, m1} * {32'd0, SCALE};
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)
      idx <= '0;
    else if (v2 && out_ready)
      idx <= (idx == LAST_IDX) ? '0 : idx + 1'b1;
  end

  assign in_ready   = adv;
  assign out_valid  = v2;
  assign out_coef   = {s2, 29'd0, 34'(p2 >> 30)};
  assign out_idx    = idx;
  assign out_offset = OFS;

  AST_SIGN_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc, 2) && $past(in_ready)) |-> (out_valid && out_coef[63] == $past(in_coef[63], 2))); // R4
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(in_valid && in_ready, 2) && $past(in_ready)) |-> out_valid); // R6
  AST_MAG_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_coef[62:34] == '0)); // R2
  AST_ZERO_MAG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(acc, 2) && $past(in_ready) && $past(in_coef[62:0], 2) == '0) |-> (out_coef[62:0] == '0)); // R5
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_coef))); // R7
  AST_STALL_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready); // R7
  AST_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    out_idx <= LAST_IDX); // R8
  AST_IDX_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && out_idx == LAST_IDX) |=> (out_idx == '0)); // R8
endmodule

// File: tb/lr_coef_scaler_bench.sv
module lr_coef_scaler_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 10;
  localparam logic [63:0] VEC_IN [NVEC] = '{
    64'h0000_0001_0000_0000,  // 1.0          R2
    64'h0000_0000_8000_0000,  // 0.5          R2
    64'h0000_0002_0000_0000,  // 2.0          R2
    64'h8000_0001_0000_0000,  // -1.0         R4
    64'h0000_0000_0000_0000,  // 0            R5
    64'h8000_0000_0000_0000,  // -0           R5
    64'h0000_0008_0000_0000,  // 8.0 clamps   R3
    64'h7FFF_FFFF_FFFF_FFFF,  // max clamps   R3
    64'h0000_0003_FFFF_FFFF,  // just below 4 R3
    64'h0000_0000_0000_0004   // 4 LSB        R2
  };
  localparam logic [63:0] VEC_EXP [NVEC] = '{
    64'h0000_0000_DBDB_DBDB,
    64'h0000_0000_6DED_EDED,
    64'h0000_0001_B7B7_B7B6,
    64'h8000_0000_DBDB_DBDB,
    64'h0000_0000_0000_0000,
    64'h8000_0000_0000_0000,
    64'h0000_0003_6F6F_6F68,
    64'h0000_0003_6F6F_6F68,
    64'h0000_0003_6F6F_6F68,
    64'h0000_0000_0000_0003
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [63:0] in_coef = '0;
  logic        out_valid;
  logic        out_ready = 1'b1;
  logic [63:0] out_coef;
  logic [3:0]  out_idx;
  logic [15:0] out_offset;

  int checks = 0;
  int fails = 0;
  int hs = 0;
  int rx = 0;
  bit mon_en = 1'b0;
  logic [63:0] held;

  lr_coef_scaler u_lr_coef_scaler (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_coef(in_coef), .out_valid(out_valid), .out_ready(out_ready),
    .out_coef(out_coef), .out_idx(out_idx), .out_offset(out_offset)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [63:0] x);
    bit r;
    in_valid = 1'b1;
    in_coef  = x;
    forever begin
      @(negedge clk);
      r = in_ready;
      @(posedge clk);
      #1;
      if (r) break;
    end
    in_valid = 1'b0;
  endtask

  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      check(out_idx == 4'((hs % 9)), "R8 index", 64'(out_idx), 64'(hs % 9));
      if (mon_en) begin
        check(out_coef == VEC_EXP[rx], $sformatf("R2/R3/R4/R5/R6 vector %0d", rx), out_coef, VEC_EXP[rx]);
        rx++;
      end
      hs++;
    end
  end

  initial begin
    int cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 5000) begin
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 5000);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1 out_valid", 64'(out_valid), 0);
    check(in_ready == 1'b1, "R1 in_ready", 64'(in_ready), 1);
    check(out_idx == 4'd0, "R1 out_idx", 64'(out_idx), 0);
    check(out_offset == 16'd257, "R9 offset", 64'(out_offset), 257);
    @(posedge clk); #1;
    rst_n = 1'b1;

    // R6 latency: accepted in cycle n, visible in cycle n+2
    @(posedge clk); #1;
    in_valid = 1'b1; in_coef = 64'h0000_0001_0000_0000;
    @(negedge clk);
    check(out_valid == 1'b0, "R6 cycle n", 64'(out_valid), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R6 cycle n+1", 64'(out_valid), 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R6 cycle n+2", 64'(out_valid), 1);
    check(out_coef == 64'h0000_0000_DBDB_DBDB, "R6 R2 value", out_coef, 64'h0000_0000_DBDB_DBDB);
    repeat (3) @(posedge clk); #1;

    // vector walk, back to back; idx wraps across the 9 boundary (R8)
    mon_en = 1'b1;
    for (int i = 0; i < NVEC; i++) send(VEC_IN[i]);
    repeat (6) @(posedge clk); #1;
    mon_en = 1'b0;
    check(rx == NVEC, "R6 result count", 64'(rx), 64'(NVEC));

    // R7 stall
    out_ready = 1'b0;
    send(64'h8000_0002_0000_0000);
    repeat (3) @(posedge clk); #1;
    @(negedge clk);
    held = out_coef;
    check(out_valid == 1'b1, "R7 valid while stalled", 64'(out_valid), 1);
    check(in_ready == 1'b0, "R7 in_ready low", 64'(in_ready), 0);
    check(out_coef == 64'h8000_0001_B7B7_B7B6, "R7 R4 stalled value", out_coef, 64'h8000_0001_B7B7_B7B6);
    in_valid = 1'b1; in_coef = 64'h0000_0001_0000_0000;
    repeat (4) @(negedge clk);
    check(out_coef == held && out_valid, "R7 value held", out_coef, held);
    check(in_ready == 1'b0, "R7 still blocked", 64'(in_ready), 0);
    @(posedge clk); #1;
    in_valid = 1'b0;
    out_ready = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b1, "R7 release edge", 64'(out_valid), 1);
    @(negedge clk);
    check(out_valid == 1'b0, "R7 drained", 64'(out_valid), 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule